// File: doc/BRIEF.md
# ADC Scan Sequencer with Per-Channel Compare

This block is the digital control logic around one successive-approximation converter that is shared, one channel at a time, by eight analog inputs. Software selects a set of channels, a resolution between 2 and 10 bits and a scan mode. It then starts a scan, either with a command or with a chosen edge on one of four trigger inputs. The sequencer visits the enabled channels in ascending order. It runs one bit trial per converter clock against an external comparator, and stores each result in that channel's own result field. At the same time it compares the result with a programmed value for that channel and sets a flag.

Software writes the configuration into shadow registers in the system clock domain. The converter domain copies them only when software issues an update command. A toggle request/acknowledge pair carries the update across the two clocks, and a busy status bit stays set until the acknowledge comes back. Trigger input 3 is meant to be wired to the end-of-scan pulse of a neighbouring converter, so that several converters can be chained.

Top module: `adc_scan_seq`

## Requirements
- R1: Register map on the system side, `bus_rdata` combinational from `bus_addr`. Address 0 holds the channel enable mask in bits [7:0], bit n enabling channel n. Address 1 is mode: resolution [3:0], continuous [4], power-down [5], trigger source [7:6], trigger edge [9:8]. Address 8+n holds channel n's compare word: value [9:0], enable [10], direction [11]. Each of these reads back what was last written. All reset to zero.
- R2: Writing bit 0 at address 2 requests an update. Status bit 0 at address 3 reads 1 from the cycle after that write until the converter domain has acknowledged. Mask, mode and compare writes made while busy are ignored. Conversions use only configuration that has been transferred by an update.
- R3: The effective resolution N is the mode value clamped to the range 2..10. Each channel takes exactly N bit trials, one per converter clock, shown by `sar_active`. The stored result is the input code with its 10-N low bits cleared, left-aligned in 10 bits.
- R4: A scan visits the enabled channels in ascending index order. It stores channel n's result in `result_flat[10n+9:10n]`. The results of disabled channels are left unchanged.
- R5: In single mode (continuous = 0) the block returns to idle after the last enabled channel. `scan_done` then pulses high for exactly one converter clock.
- R6: In continuous mode, when the last enabled channel is stored the scan begins again from the lowest enabled channel. `scan_done` pulses once per scan. Once an update clears the continuous bit, the block stops at the end of the scan in progress.
- R7: Writing bit 1 at address 2 starts a scan. This does not depend on the busy state.
- R8: Trigger edge codes are 0 = off, 1 = rising, 2 = falling, 3 = both. The trigger source field picks one bit of `trig_in`. That bit passes through two flip-flops in the converter domain, and an edge of the selected kind starts a scan. Edges on unselected inputs have no effect.
- R9: A start, from either software or a trigger, is ignored while a scan is running and when the active channel mask is empty.
- R10: When channel n's result is stored, `cmp_flag[n]` becomes 1 only if compare is enabled. With direction 0 it needs result < value; with direction 1 it needs result >= value. Otherwise it becomes 0.
- R11: Setting power-down through an update aborts a running scan and prevents any bit trials or `scan_done`. Starts are ignored while power-down is set.
- R12: The channel mask and resolution are latched at each scan start, including the restart in continuous mode. An update that arrives during a scan does not change that scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register side |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 12 | Register write data |
| bus_rdata | output | 12 | Register read data |
| clk_cnv | input | 1 | Converter clock |
| rst_cnv | input | 1 | Synchronous active-high reset, converter domain |
| trig_in | input | 4 | Trigger sources (3 = neighbouring converter's end of scan) |
| sar_active | output | 1 | A bit trial is presented this cycle |
| sar_ch | output | 3 | Channel routed to the comparator |
| sar_code | output | 10 | Trial code for the comparator |
| sar_ge | input | 1 | Comparator: input is at or above `sar_code` |
| result_flat | output | 80 | Per-channel results, channel n at bits [10n+9:10n] |
| cmp_flag | output | 8 | Per-channel compare flags |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |

## Verification
A start request can reach the converter domain in the same cycle as a scan that is already running, or together with a power-down update. The bench issues a second software start partway through an 80-trial scan. It then counts trials and `scan_done` pulses to confirm that the extra start was dropped. A configuration update can also arrive while the channel loop is in progress. The bench commits a new mask and resolution, then a power-down, partway through a long scan. It judges the result by the trial count of that scan and of the next one, and by the missing end-of-scan pulse after the abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    parameter int NCH  = 8;
    parameter int RW   = 10;
    parameter int NSRC = 4;
    parameter int AW   = 4;
    parameter int DW   = 12;
    parameter int RMIN = 2;

    localparam int CHW = $clog2(NCH);
    localparam int BPW = $clog2(RW + 1);
    localparam int SW  = $clog2(NSRC);

    localparam int A_MASK = 0;
    localparam int A_MODE = 1;
    localparam int A_CMD  = 2;
    localparam int A_STAT = 3;
    localparam int A_CMP0 = 8;

    typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_e;
    typedef enum logic {S_IDLE, S_CONV} seq_state_e;

    typedef struct packed {
        logic [NCH-1:0]         chmask;
        logic [BPW-1:0]         res;
        logic                   cont;
        logic                   pd;
        logic [SW-1:0]          tsrc;
        edge_e                  tedge;
        logic [NCH-1:0][RW-1:0] cval;
        logic [NCH-1:0]         cen;
        logic [NCH-1:0]         cdir;
    } cfg_t;

    typedef struct packed {
        logic           hit;
        logic [CHW-1:0] idx;
    } pick_t;

    function automatic logic [BPW-1:0] clamp_res(input logic [BPW-1:0] r);
        if (int'(r) < RMIN) return BPW'(RMIN);
        if (int'(r) > RW)   return BPW'(RW);
        return r;
    endfunction

    // lowest set bit of m at an index not below 'from'
    function automatic pick_t first_from(input logic [NCH-1:0] m, input logic [CHW:0] from);
        pick_t p;
        p = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && i >= int'(from)) begin
                p.hit = 1'b1;
                p.idx = CHW'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output cfg_t          shadow,
    output logic          req_tgl,
    output logic          st_tgl,
    input  logic          ack_tgl
);
    logic ack_s1, ack_s2, busy, is_cmp;
    logic [CHW-1:0] cidx;

    assign busy   = req_tgl ^ ack_s2;
    assign is_cmp = ({1'b0, addr} >= (AW+1)'(A_CMP0)) && ({1'b0, addr} < (AW+1)'(A_CMP0 + NCH));
    assign cidx   = CHW'(addr - AW'(A_CMP0));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            req_tgl <= 1'b0;
            st_tgl  <= 1'b0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            if (wr) begin
                if (addr == AW'(A_CMD)) begin
                    if (wdata[0] && !busy) req_tgl <= ~req_tgl;
                    if (wdata[1])          st_tgl  <= ~st_tgl;
                end else if (!busy) begin
                    if (addr == AW'(A_MASK)) begin
                        shadow.chmask <= wdata[NCH-1:0];
                    end else if (addr == AW'(A_MODE)) begin
                        shadow.res   <= wdata[BPW-1:0];
                        shadow.cont  <= wdata[4];
                        shadow.pd    <= wdata[5];
                        shadow.tsrc  <= wdata[6 +: SW];
                        shadow.tedge <= edge_e'(wdata[9:8]);
                    end else if (is_cmp) begin
                        shadow.cval[cidx] <= wdata[RW-1:0];
                        shadow.cen[cidx]  <= wdata[RW];
                        shadow.cdir[cidx] <= wdata[RW+1];
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_MASK))      rdata = DW'(shadow.chmask);
        else if (addr == AW'(A_MODE)) rdata = DW'({shadow.tedge, shadow.tsrc, shadow.pd, shadow.cont, shadow.res});
        else if (addr == AW'(A_STAT)) rdata = DW'(busy);
        else if (is_cmp)              rdata = DW'({shadow.cdir[cidx], shadow.cen[cidx], shadow.cval[cidx]});
    end

    // R2: staged configuration is frozen while a transfer is outstanding
    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(shadow));
endmodule

// File: rtl/adc_cfg_sync.sv
module adc_cfg_sync
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t shadow,
    input  logic req_tgl,
    input  logic st_tgl,
    output cfg_t act,
    output logic ack_tgl,
    output logic sw_start
);
    logic r1, r2, r3, s1, s2, s3;

    assign sw_start = s2 ^ s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            {r1, r2, r3, s1, s2, s3} <= '0;
            act     <= '0;
            ack_tgl <= 1'b0;
        end else begin
            r1 <= req_tgl; r2 <= r1; r3 <= r2;
            s1 <= st_tgl;  s2 <= s1; s3 <= s2;
            if (r2 != r3) begin
                act     <= shadow;
                ack_tgl <= r2;
            end
        end
    end

    // R2: the acknowledge moves only after a request edge has been seen
    assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        (ack_tgl != $past(ack_tgl)) |-> ($past(r2) != $past(r3)));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] trig_in,
    input  logic [SW-1:0]   sel,
    input  edge_e           tedge,
    output logic            pulse
);
    logic [NSRC-1:0] m1, m2, prev;
    logic cur, old;

    assign cur = m2[sel];
    assign old = prev[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            m1 <= '0; m2 <= '0; prev <= '0;
        end else begin
            m1 <= trig_in; m2 <= m1; prev <= m2;
        end
    end

    always_comb begin
        unique case (tedge)
            EDGE_RISE: pulse = cur & ~old;
            EDGE_FALL: pulse = ~cur & old;
            EDGE_BOTH: pulse = cur ^ old;
            default:   pulse = 1'b0;
        endcase
    end

    // R8: a start from the trigger path needs an enabled edge mode
    assert_edge_off_R8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (tedge != EDGE_OFF));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NCH-1:0]         act_mask,
    input  logic [BPW-1:0]         act_res,
    input  logic                   act_cont,
    input  logic                   act_pd,
    input  logic [NCH-1:0][RW-1:0] cval,
    input  logic [NCH-1:0]         cen,
    input  logic [NCH-1:0]         cdir,
    input  logic                   sar_ge,
    output logic                   sar_active,
    output logic [CHW-1:0]         sar_ch,
    output logic [RW-1:0]          sar_code,
    output logic [NCH-1:0][RW-1:0] res_q,
    output logic [NCH-1:0]         flag_q,
    output logic                   scan_done
);
    seq_state_e     state;
    logic [CHW-1:0] ch;
    logic [BPW-1:0] bitpos, lres, lsb;
    logic [RW-1:0]  acc, acc_nx;
    logic [NCH-1:0] lmask;
    logic           last;
    pick_t          first_act, nxt;

    assign lsb        = BPW'(RW) - lres;
    assign sar_code   = acc | (RW'(1) << bitpos);
    assign acc_nx     = sar_ge ? sar_code : acc;
    assign last       = (bitpos == lsb);
    assign sar_active = (state == S_CONV) && !act_pd;
    assign sar_ch     = ch;
    assign first_act  = first_from(act_mask, '0);
    assign nxt        = first_from(lmask, {1'b0, ch} + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ch        <= '0;
            bitpos    <= '0;
            acc       <= '0;
            lmask     <= '0;
            lres      <= BPW'(RMIN);
            res_q     <= '0;
            flag_q    <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start && !act_pd && first_act.hit) begin
                        lmask  <= act_mask;
                        lres   <= clamp_res(act_res);
                        ch     <= first_act.idx;
                        bitpos <= BPW'(RW - 1);
                        acc    <= '0;
                        state  <= S_CONV;
                    end
                end
                S_CONV: begin
                    if (act_pd) begin
                        state <= S_IDLE;
                    end else if (!last) begin
                        bitpos <= bitpos - 1'b1;
                        acc    <= acc_nx;
                    end else begin
                        res_q[ch]  <= acc_nx;
                        flag_q[ch] <= cen[ch] && (cdir[ch] ? (acc_nx >= cval[ch]) : (acc_nx < cval[ch]));
                        acc        <= '0;
                        bitpos     <= BPW'(RW - 1);
                        if (nxt.hit) begin
                            ch <= nxt.idx;
                        end else begin
                            scan_done <= 1'b1;
                            if (act_cont && first_act.hit) begin
                                lmask <= act_mask;
                                lres  <= clamp_res(act_res);
                                ch    <= first_act.idx;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4: only channels of the latched mask reach the comparator
    assert_trial_in_mask_R4: assert property (@(posedge clk) disable iff (rst)
        sar_active |-> lmask[ch]);
    // R3: trials never go below the lowest bit of the latched resolution
    assert_bit_floor_R3: assert property (@(posedge clk) disable iff (rst)
        sar_active |-> (bitpos >= lsb));
    // R5: end of scan is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);
    // R11: a held power-down leaves the sequencer idle
    assert_pd_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (act_pd && $past(act_pd)) |-> (state == S_IDLE));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic              clk_sys,
    input  logic              rst_sys,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              clk_cnv,
    input  logic              rst_cnv,
    input  logic [NSRC-1:0]   trig_in,
    output logic              sar_active,
    output logic [CHW-1:0]    sar_ch,
    output logic [RW-1:0]     sar_code,
    input  logic              sar_ge,
    output logic [NCH*RW-1:0] result_flat,
    output logic [NCH-1:0]    cmp_flag,
    output logic              scan_done
);
    cfg_t shadow, act;
    logic req_tgl, st_tgl, ack_tgl, sw_start, trig_pulse;
    logic [NCH-1:0][RW-1:0] res_q;

    adc_cfg_regs u_regs (
        .clk(clk_sys), .rst(rst_sys), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .shadow(shadow),
        .req_tgl(req_tgl), .st_tgl(st_tgl), .ack_tgl(ack_tgl)
    );

    adc_cfg_sync u_sync (
        .clk(clk_cnv), .rst(rst_cnv), .shadow(shadow), .req_tgl(req_tgl),
        .st_tgl(st_tgl), .act(act), .ack_tgl(ack_tgl), .sw_start(sw_start)
    );

    adc_trig_edge u_trig (
        .clk(clk_cnv), .rst(rst_cnv), .trig_in(trig_in), .sel(act.tsrc),
        .tedge(act.tedge), .pulse(trig_pulse)
    );

    adc_sar_seq u_seq (
        .clk(clk_cnv), .rst(rst_cnv), .start(sw_start | trig_pulse),
        .act_mask(act.chmask), .act_res(act.res), .act_cont(act.cont),
        .act_pd(act.pd), .cval(act.cval), .cen(act.cen), .cdir(act.cdir),
        .sar_ge(sar_ge), .sar_active(sar_active), .sar_ch(sar_ch),
        .sar_code(sar_code), .res_q(res_q), .flag_q(cmp_flag),
        .scan_done(scan_done)
    );

    assign result_flat = res_q;
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/100ps
module adc_scan_seq_tb_top;
    logic        clk_sys = 1'b0, clk_cnv = 1'b0;
    logic        rst_sys = 1'b1, rst_cnv = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic [3:0]  trig_in = '0;
    logic        sar_active, sar_ge, scan_done;
    logic [2:0]  sar_ch;
    logic [9:0]  sar_code;
    logic [79:0] result_flat;
    logic [7:0]  cmp_flag;

    logic [9:0] vin [8];
    int exp_res [8];
    int exp_flg [8];
    int tests = 0, fails = 0;
    int trials = 0, done_cnt = 0, logn = 0;
    int chlog [1024];
    bit finished = 0;

    assign sar_ge = (vin[sar_ch] >= sar_code);

    always #2 clk_sys = ~clk_sys;
    initial begin
        #1.5;
        forever #3 clk_cnv = ~clk_cnv;
    end

    adc_scan_seq dut_i (
        .clk_sys(clk_sys), .rst_sys(rst_sys), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_cnv(clk_cnv), .rst_cnv(rst_cnv),
        .trig_in(trig_in), .sar_active(sar_active), .sar_ch(sar_ch), .sar_code(sar_code),
        .sar_ge(sar_ge), .result_flat(result_flat), .cmp_flag(cmp_flag), .scan_done(scan_done)
    );

    always @(negedge clk_cnv) begin
        if (sar_active) begin
            trials = trials + 1;
            if (sar_code == 10'h200 && logn < 1024) begin
                chlog[logn] = int'(sar_ch);
                logn = logn + 1;
            end
        end
        if (scan_done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk_sys);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 12'(d);
        @(negedge clk_sys);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk_sys);
        bus_addr = 4'(a);
        #1 d = int'(bus_rdata);
    endtask

    task automatic commit();
        int st = 1;
        bus_write(2, 1);
        for (int k = 0; k < 100 && st != 0; k++) bus_read(3, st);
        chk("R2 busy clears", st == 0, st, 0);
    endtask

    task automatic sw_start();
        bus_write(2, 2);
    endtask

    task automatic cnv_wait(input int n);
        repeat (n) @(negedge clk_cnv);
    endtask

    task automatic wait_done(input int target);
        for (int k = 0; k < 3000 && done_cnt < target; k++) @(negedge clk_cnv);
    endtask

    function automatic int res_of(int v, int n);
        return (v >> (10 - n)) << (10 - n);
    endfunction

    function automatic int res_at(int c);
        return int'(result_flat[c*10 +: 10]);
    endfunction

    // one single-mode scan with expected values from the requirements
    task automatic run_single(input int i, input int m, input int rraw);
        int n, pop, t0, l0, d0, k, val, en, dir;
        n = (rraw < 2) ? 2 : ((rraw > 10) ? 10 : rraw);
        pop = $countones(8'(m));
        for (int c = 0; c < 8; c++) vin[c] = 10'((i * 37 + c * 113 + 5) % 1024);
        bus_write(0, m);
        bus_write(1, rraw);
        for (int c = 0; c < 8; c++) begin
            val = ((i + c) % 3 == 0) ? res_of(int'(vin[c]), n) : (c * 151 + i * 7) % 1024;
            en  = ((c + i) % 4 != 3) ? 1 : 0;
            dir = (c + i) % 2;
            bus_write(8 + c, val | (en << 10) | (dir << 11));
            if (m[c]) begin
                exp_res[c] = res_of(int'(vin[c]), n);
                exp_flg[c] = (en == 0) ? 0 : (dir == 1 ? int'(exp_res[c] >= val) : int'(exp_res[c] < val));
            end
        end
        commit();
        t0 = trials; l0 = logn; d0 = done_cnt;
        sw_start();
        wait_done(d0 + 1);
        cnv_wait(20);
        chk("R3 trial count", trials - t0 == n * pop, trials - t0, n * pop);
        chk("R5 one done pulse", done_cnt - d0 == 1, done_cnt - d0, 1);
        chk("R5 idle after scan", sar_active == 1'b0, int'(sar_active), 0);
        k = 0;
        for (int c = 0; c < 8; c++) begin
            if (m[c]) begin
                chk("R4 ascending order", chlog[l0 + k] == c, chlog[l0 + k], c);
                k++;
            end
            chk("R3 R4 result value", res_at(c) == exp_res[c], res_at(c), exp_res[c]);
            chk("R10 compare flag", int'(cmp_flag[c]) == exp_flg[c], int'(cmp_flag[c]), exp_flg[c]);
        end
    endtask

    initial begin
        int d, d0, t0, l0;
        bit ok;
        for (int c = 0; c < 8; c++) begin vin[c] = '0; exp_res[c] = 0; exp_flg[c] = 0; end
        repeat (10) @(negedge clk_sys);
        rst_sys = 1'b0;
        @(negedge clk_cnv);
        rst_cnv = 1'b0;
        cnv_wait(3);

        // reset state
        chk("R1 reset results", result_flat == '0, int'(result_flat[9:0]), 0);
        chk("R1 reset flags", cmp_flag == '0, int'(cmp_flag), 0);
        chk("R5 reset done", scan_done == 1'b0, int'(scan_done), 0);
        bus_read(1, d); chk("R1 reset mode", d == 0, d, 0);
        bus_read(3, d); chk("R2 reset busy", d == 0, d, 0);

        // register readback
        bus_write(0, 8'hA5); bus_read(0, d); chk("R1 mask readback", d == 8'hA5, d, 8'hA5);
        bus_write(1, 12'h2F7); bus_read(1, d); chk("R1 mode readback", d == 12'h2F7, d, 12'h2F7);
        bus_write(13, 12'hA3C); bus_read(13, d); chk("R1 compare readback", d == 12'hA3C, d, 12'hA3C);
        bus_write(1, 0);

        // staged config not yet transferred: start sees an empty active mask
        t0 = trials; d0 = done_cnt;
        sw_start(); cnv_wait(40);
        chk("R2 no effect before update", trials == t0, trials - t0, 0);
        chk("R9 empty mask start ignored", done_cnt == d0, done_cnt - d0, 0);

        // busy window and blocked writes
        bus_write(2, 1);
        bus_read(3, d); chk("R2 busy after request", d == 1, d, 1);
        bus_write(0, 8'h11);
        bus_read(0, d); chk("R2 write while busy ignored", d == 8'hA5, d, 8'hA5);
        for (int k = 0; k < 100 && d != 0; k++) bus_read(3, d);
        chk("R2 busy clears", d == 0, d, 0);

        // sweep of resolution codes 0..15 and channel masks
        for (int i = 0; i < 16; i++) run_single(i, (i * 29 + 1) % 256, i);
        run_single(16, 8'hFF, 10);
        run_single(17, 8'h80, 2);

        // R9: second start during an 80-trial scan
        bus_write(0, 8'hFF); bus_write(1, 10); commit();
        t0 = trials; d0 = done_cnt;
        sw_start(); cnv_wait(25); sw_start();
        wait_done(d0 + 1); cnv_wait(150);
        chk("R9 start during scan ignored", done_cnt - d0 == 1, done_cnt - d0, 1);
        chk("R9 trials of one scan", trials - t0 == 80, trials - t0, 80);

        // R12: update during scan does not change that scan
        t0 = trials; d0 = done_cnt;
        sw_start(); cnv_wait(10);
        bus_write(0, 8'h03); bus_write(1, 2); commit();
        wait_done(d0 + 1); cnv_wait(10);
        chk("R12 running scan keeps settings", trials - t0 == 80, trials - t0, 80);
        t0 = trials;
        sw_start(); wait_done(d0 + 2); cnv_wait(10);
        chk("R12 next scan uses update", trials - t0 == 4, trials - t0, 4);

        // R6: continuous scanning of channels 2 and 5
        bus_write(0, 8'h24); bus_write(1, 4 | 16); commit();
        l0 = logn; d0 = done_cnt;
        sw_start(); wait_done(d0 + 3);
        chk("R6 repeated scans", done_cnt - d0 >= 3, done_cnt - d0, 3);
        ok = 1;
        for (int k = 0; k < 6; k++) if (chlog[l0 + k] != ((k % 2 == 0) ? 2 : 5)) ok = 0;
        chk("R6 restart from lowest channel", ok, chlog[l0 + 2], 2);
        bus_write(1, 4); commit(); cnv_wait(30);
        d0 = done_cnt; cnv_wait(200);
        chk("R6 stops after clear", done_cnt == d0, done_cnt - d0, 0);
        chk("R6 idle after stop", sar_active == 1'b0, int'(sar_active), 0);

        // R8: trigger source 1, rising edge, one short channel
        bus_write(0, 8'h01); bus_write(1, 2 | (1 << 6) | (1 << 8)); commit();
        d0 = done_cnt;
        @(negedge clk_cnv) trig_in[2] = 1'b1; cnv_wait(20); trig_in[2] = 1'b0; cnv_wait(20);
        chk("R8 unselected source ignored", done_cnt == d0, done_cnt - d0, 0);
        trig_in[1] = 1'b1; cnv_wait(20);
        chk("R8 rising edge starts", done_cnt - d0 == 1, done_cnt - d0, 1);
        trig_in[1] = 1'b0; cnv_wait(20);
        chk("R8 falling ignored in rising mode", done_cnt - d0 == 1, done_cnt - d0, 1);
        bus_write(1, 2 | (1 << 6) | (2 << 8)); commit();
        d0 = done_cnt;
        @(negedge clk_cnv) trig_in[1] = 1'b1; cnv_wait(20);
        chk("R8 rising ignored in falling mode", done_cnt == d0, done_cnt - d0, 0);
        trig_in[1] = 1'b0; cnv_wait(20);
        chk("R8 falling edge starts", done_cnt - d0 == 1, done_cnt - d0, 1);
        bus_write(1, 2 | (1 << 6) | (3 << 8)); commit();
        d0 = done_cnt;
        @(negedge clk_cnv) trig_in[1] = 1'b1; cnv_wait(20); trig_in[1] = 1'b0; cnv_wait(20);
        chk("R8 both edges start", done_cnt - d0 == 2, done_cnt - d0, 2);
        bus_write(1, 2 | (1 << 6)); commit();
        d0 = done_cnt;
        @(negedge clk_cnv) trig_in[1] = 1'b1; cnv_wait(20); trig_in[1] = 1'b0; cnv_wait(20);
        chk("R8 edge mode off", done_cnt == d0, done_cnt - d0, 0);

        // R7: software start independent of busy
        bus_write(0, 8'hFF); bus_write(1, 10); commit();
        d0 = done_cnt;
        bus_write(2, 3); wait_done(d0 + 1); cnv_wait(10);
        chk("R7 start with update request", done_cnt - d0 == 1, done_cnt - d0, 1);

        // R11: power-down mid-scan
        t0 = trials; d0 = done_cnt;
        sw_start(); cnv_wait(15);
        bus_write(1, 10 | 32); commit(); cnv_wait(150);
        chk("R11 abort no done", done_cnt == d0, done_cnt - d0, 0);
        chk("R11 abort cuts trials", (trials - t0) < 80, trials - t0, 79);
        chk("R11 no activity", sar_active == 1'b0, int'(sar_active), 0);
        t0 = trials;
        sw_start(); cnv_wait(60);
        chk("R11 start ignored in power-down", trials == t0, trials - t0, 0);
        bus_write(1, 10); commit();
        sw_start(); wait_done(d0 + 1); cnv_wait(10);
        chk("R11 resumes after power-up", done_cnt - d0 == 1, done_cnt - d0, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule